// File: doc/BRIEF.md
# Processor Control-Pin Interrupt Front End

This block sits between seven processor control input pins and the core's pending-interrupt and run-control state. On every clock it compares the sampled pin levels with a register holding the levels seen on the previous clock. Any difference is decoded per pin into updates of a twelve-bit pending-interrupt vector, a halted flag or a one-cycle reset request. A pin whose level has not changed causes nothing.

Pins differ in how they are read. External interrupt, thermal and soft reset are level-sensitive: their pending bit copies the pin on each change. Machine check latches only on a falling edge. Checkstop drives the halted flag directly. Hard reset pulses a reset request when it rises. Time-base enable is only recorded. The core clears serviced pending bits through a one-hot acknowledge input. Five internal timer event strobes set the upper pending bits.

Top module: `ctrl_pin_irq_front`

## Requirements
- R1: Pin indices are fixed: hard reset 0, soft reset 1, checkstop 2, time-base enable 3, machine check 4, external interrupt 5, thermal 6. `pin_state_o` shows, one clock later, the pin levels sampled at each clock edge.
- R2: If the pins equal the stored state and there is no acknowledge and no timer strobe, the pending vector and halted flag keep their values and no reset request is issued.
- R3: Pending bit 2 (external) is set when pin 5 rises and cleared when pin 5 falls.
- R4: Pending bit 6 (thermal) is set when pin 6 rises and cleared when pin 6 falls.
- R5: Pending bit 1 (machine check) is set by a falling edge on pin 4. A rising edge has no effect, and only an acknowledge clears the bit.
- R6: A rising edge on pin 2 sets `halted_o`. A falling edge clears it.
- R7: Pending bit 0 (soft reset) is set when pin 1 rises and cleared when pin 1 falls.
- R8: A change on pin 3 updates `pin_state_o` bit 3 only. The pending vector, halted flag and reset request are unaffected.
- R9: A rising edge on pin 0 produces `rst_req_o` high for exactly one clock. A falling edge produces nothing.
- R10: Timer strobe bit k sets pending bit 7+k: decrementer 7, hypervisor decrementer 8, programmable interval timer 9, fixed interval timer 10, watchdog 11.
- R11: An `ack_i` bit clears its pending bit on the next clock edge. A level pin that is still high does not set its bit again until the pin next changes. A set event in the same cycle as the acknowledge wins.
- R12: After reset, the stored pin state, pending vector, halted flag and reset request are all zero. Pending bits 3, 4 and 5 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 7 | Control pin levels |
| ack_i | input | 12 | One-hot acknowledge of pending bits |
| tmr_evt_i | input | 5 | Internal timer event strobes |
| pend_o | output | 12 | Pending-interrupt vector |
| halted_o | output | 1 | Core halted by checkstop |
| rst_req_o | output | 1 | One-cycle hard reset request |
| pin_state_o | output | 7 | Stored previous pin levels |

## Verification
The bench builds the block with its default widths: seven pins, a twelve-bit pending vector and five timer strobes. At these widths every ordered pair of the 128 pin patterns can be applied back to back, so every rising and falling combination on every pin is reached from every prior state. Acknowledge and timer patterns are mixed in arithmetically. Directed sequences cover the cases the sweep cannot isolate cleanly: a quiet hold, re-assertion after an acknowledge, and an acknowledge that collides with a set event.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  parameter int unsigned NUM_PINS = 7;
  parameter int unsigned PEND_W   = 12;
  parameter int unsigned TMR_W    = 5;
  parameter int unsigned TMR_LSB  = 7;

  // pin indices
  parameter int unsigned PIN_HRST  = 0;
  parameter int unsigned PIN_SRST  = 1;
  parameter int unsigned PIN_CSTOP = 2;
  parameter int unsigned PIN_TBEN  = 3;
  parameter int unsigned PIN_MCHK  = 4;
  parameter int unsigned PIN_EXT   = 5;
  parameter int unsigned PIN_THRM  = 6;

  // pending bit indices
  parameter int unsigned PB_RST  = 0;
  parameter int unsigned PB_MCHK = 1;
  parameter int unsigned PB_EXT  = 2;
  parameter int unsigned PB_THRM = 6;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LEVEL = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_TIMER = 2'd3
  } src_kind_e;

  typedef struct packed {
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
  } pin_evt_t;

  function automatic src_kind_e kind_of(int unsigned b);
    if (b == PB_RST || b == PB_EXT || b == PB_THRM) return SRC_LEVEL;
    if (b == PB_MCHK) return SRC_FALL;
    if (b >= TMR_LSB && b < TMR_LSB + TMR_W) return SRC_TIMER;
    return SRC_NONE;
  endfunction

  function automatic int unsigned pin_of(int unsigned b);
    case (b)
      PB_RST:  return PIN_SRST;
      PB_MCHK: return PIN_MCHK;
      PB_EXT:  return PIN_EXT;
      PB_THRM: return PIN_THRM;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ipf_pin_track.sv
module ipf_pin_track
  import ipf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] prev_o,
  output pin_evt_t            evt_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  assign evt_o.rise = pins_i & ~prev_q;
  assign evt_o.fall = ~pins_i & prev_q;
  assign prev_o     = prev_q;

  assert_track_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prev_q == $past(pins_i));
endmodule

// File: rtl/ipf_pend_ctrl.sv
module ipf_pend_ctrl
  import ipf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pin_evt_t          evt_i,
  input  logic [PEND_W-1:0] ack_i,
  input  logic [TMR_W-1:0]  tmr_i,
  output logic [PEND_W-1:0] pend_o
);
  logic [PEND_W-1:0] pend_q;
  logic              unused_evt;
  assign unused_evt = ^evt_i;

  for (genvar g = 0; g < PEND_W; g++) begin : g_bit
    localparam src_kind_e   KIND = kind_of(g);
    localparam int unsigned PIN  = pin_of(g);
    if (KIND == SRC_LEVEL) begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               pend_q[g] <= 1'b0;
        else if (evt_i.rise[PIN])  pend_q[g] <= 1'b1;
        else if (evt_i.fall[PIN])  pend_q[g] <= 1'b0;
        else if (ack_i[g])         pend_q[g] <= 1'b0;
      end
    end else if (KIND == SRC_FALL) begin : g_fall
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               pend_q[g] <= 1'b0;
        else if (evt_i.fall[PIN])  pend_q[g] <= 1'b1;
        else if (ack_i[g])         pend_q[g] <= 1'b0;
      end
    end else if (KIND == SRC_TIMER) begin : g_tmr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   pend_q[g] <= 1'b0;
        else if (tmr_i[g - TMR_LSB])   pend_q[g] <= 1'b1;
        else if (ack_i[g])             pend_q[g] <= 1'b0;
      end
    end else begin : g_none
      logic unused_ack;
      assign unused_ack = ack_i[g];
      assign pend_q[g]  = 1'b0;
    end
  end

  assign pend_o = pend_q;

  assert_ext_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.rise[PIN_EXT] |=> pend_q[PB_EXT]);
  assert_ext_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.fall[PIN_EXT] |=> !pend_q[PB_EXT]);
  assert_thrm_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.rise[PIN_THRM] |=> pend_q[PB_THRM]);
  assert_mchk_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[PB_MCHK] && !ack_i[PB_MCHK] |=> pend_q[PB_MCHK]);
  assert_mchk_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.fall[PIN_MCHK] |=> pend_q[PB_MCHK]);
  assert_srst_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.rise[PIN_SRST] |=> pend_q[PB_RST]);
  assert_tmr_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_i[0] |=> pend_q[TMR_LSB]);
  assert_unused_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[5:3] == 3'b000);
endmodule

// File: rtl/ipf_run_ctrl.sv
module ipf_run_ctrl
  import ipf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_evt_t evt_i,
  output logic     halted_o,
  output logic     rst_req_o
);
  logic halted_q, rst_req_q;
  logic unused_evt;
  assign unused_evt = ^evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q  <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (evt_i.rise[PIN_CSTOP])      halted_q <= 1'b1;
      else if (evt_i.fall[PIN_CSTOP]) halted_q <= 1'b0;
      rst_req_q <= evt_i.rise[PIN_HRST];
    end
  end

  assign halted_o  = halted_q;
  assign rst_req_o = rst_req_q;

  assert_halt_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.rise[PIN_CSTOP] |=> halted_q);
  assert_halt_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.fall[PIN_CSTOP] |=> !halted_q);
  assert_rst_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
endmodule

// File: rtl/ctrl_pin_irq_front.sv
module ctrl_pin_irq_front
  import ipf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [PEND_W-1:0]   ack_i,
  input  logic [TMR_W-1:0]    tmr_evt_i,
  output logic [PEND_W-1:0]   pend_o,
  output logic                halted_o,
  output logic                rst_req_o,
  output logic [NUM_PINS-1:0] pin_state_o
);
  pin_evt_t            evt;
  logic [NUM_PINS-1:0] prev;

  ipf_pin_track u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_i),
    .prev_o (prev),
    .evt_o  (evt)
  );

  ipf_pend_ctrl u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .ack_i  (ack_i),
    .tmr_i  (tmr_evt_i),
    .pend_o (pend_o)
  );

  ipf_run_ctrl u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .halted_o  (halted_o),
    .rst_req_o (rst_req_o)
  );

  assign pin_state_o = prev;

  assert_quiet_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i == pin_state_o) && (ack_i == '0) && (tmr_evt_i == '0)
    |=> $stable(pend_o) && $stable(halted_o) && !rst_req_o);
  assert_tben_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pins_i ^ pin_state_o) == NUM_PINS'(1 << PIN_TBEN)) && (ack_i == '0) && (tmr_evt_i == '0)
    |=> $stable(pend_o) && $stable(halted_o) && !rst_req_o);
endmodule

// File: tb/ctrl_pin_irq_front_tb_top.sv
`timescale 1ns/1ps
module ctrl_pin_irq_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  pins = '0;
  logic [11:0] ack = '0;
  logic [4:0]  tmr = '0;
  logic [11:0] pend;
  logic        halted, rst_req;
  logic [6:0]  pst;

  int n_chk = 0, n_bad = 0;
  logic [6:0]  m_prev = '0;
  logic [11:0] m_pend = '0;
  logic        m_halt = 1'b0, m_rr = 1'b0;

  always #2.5 clk = ~clk;

  ctrl_pin_irq_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .ack_i(ack), .tmr_evt_i(tmr),
    .pend_o(pend), .halted_o(halted), .rst_req_o(rst_req), .pin_state_o(pst)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 pin_state",       32'(pst),           32'(m_prev));
    chk("R7 soft reset bit",  32'(pend[0]),       32'(m_pend[0]));
    chk("R5 mchk bit",        32'(pend[1]),       32'(m_pend[1]));
    chk("R3 ext bit",         32'(pend[2]),       32'(m_pend[2]));
    chk("R12 unused bits",    32'(pend[5:3]),     32'(0));
    chk("R4 thermal bit",     32'(pend[6]),       32'(m_pend[6]));
    chk("R10 timer bits",     32'(pend[11:7]),    32'(m_pend[11:7]));
    chk("R6 halted",          32'(halted),        32'(m_halt));
    chk("R9 reset request",   32'(rst_req),       32'(m_rr));
  endtask

  task automatic step(logic [6:0] p, logic [11:0] a, logic [4:0] t);
    logic [6:0] ch;
    @(negedge clk);
    pins = p; ack = a; tmr = t;
    ch = p ^ m_prev;
    m_pend = m_pend & ~a;
    m_pend[11:7] = m_pend[11:7] | t;
    if (ch[1]) m_pend[0] = p[1];
    if (ch[4] && !p[4]) m_pend[1] = 1'b1;
    if (ch[5]) m_pend[2] = p[5];
    if (ch[6]) m_pend[6] = p[6];
    m_pend[5:3] = 3'b000;
    if (ch[2]) m_halt = p[2];
    m_rr = ch[0] & p[0];
    m_prev = p;
    @(posedge clk); #1;
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] hold;
    repeat (3) @(negedge clk);
    #1;
    check_all(); // R12 reset state
    chk("R12 reset pending", 32'(pend), 32'(0));
    rst_n = 1'b1;

    // R9 one-cycle pulse, R2 quiet hold
    step(7'b0000001, '0, '0);
    chk("R9 pulse high", 32'(rst_req), 32'(1));
    step(7'b0000001, '0, '0);
    chk("R9 pulse ends", 32'(rst_req), 32'(0));
    hold = pend;
    step(7'b0000001, '0, '0);
    chk("R2 quiet hold", 32'(pend), 32'(hold));

    // R8 time-base enable only recorded
    step(7'b0001001, '0, '0);
    chk("R8 tben recorded", 32'(pst[3]), 32'(1));
    chk("R8 pend untouched", 32'(pend), 32'(hold));

    // R11 ack while ext still high, no re-set
    step(7'b0101001, '0, '0);
    chk("R11 ext set", 32'(pend[2]), 32'(1));
    step(7'b0101001, 12'h004, '0);
    chk("R11 ack clears", 32'(pend[2]), 32'(0));
    step(7'b0101001, '0, '0);
    chk("R11 no re-set", 32'(pend[2]), 32'(0));
    // R11 set event wins over ack in same cycle
    step(7'b1101001, 12'h040, '0);
    chk("R11 event wins", 32'(pend[6]), 32'(1));
    step(7'b1101001, 12'h080, 5'b00001);
    chk("R11 timer wins", 32'(pend[7]), 32'(1));
    // R5 rising edge does nothing, bit sticky
    step(7'b1111001, '0, '0);
    chk("R5 rise no set", 32'(pend[1]), 32'(0));
    step(7'b1101001, '0, '0);
    chk("R5 fall sets", 32'(pend[1]), 32'(1));
    step(7'b1111001, '0, '0);
    chk("R5 sticky", 32'(pend[1]), 32'(1));

    // exhaustive pair sweep
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        step(7'(a), 12'((a * 5 + b * 3) & ((a ^ b) & 1 ? 12'hFFF : 12'h000)), 5'((a & b) >> 2));
        step(7'(b), 12'(((b & 3) == 0) ? (b * 37) : 0), 5'(((a + b) & 7) == 0 ? b : 0));
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule